// File: doc/BRIEF.md
# Staggered DRAM Refresh Scheduler

This block keeps every bank of a memory channel refreshed without ever taking the whole channel offline at once. It is configured with the per-bank refresh period, which is the number of memory cycles allowed between refreshing one row of a bank and the next row of that same bank. It splits that period evenly across all banks in the channel and counts down the resulting short interval. Each time the interval expires, it asks the request scheduler to refresh one bank. The target bank moves to the next one in turn, so each bank is refreshed once per full period.

The total bank count is the product of three parameters: banks per rank, ranks per module and modules per channel. With the defaults this is 8, 2 and 2, giving 32 banks. The default period is 1560 cycles, so a request is raised every 48 cycles. A faster speed grade is supported by raising the period parameter, for example to 3120.

The request is a level that stays high until the scheduler grants it. If the next interval expires before the scheduler has granted the previous request, a sticky overrun flag is raised.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rfr_req` is 0, `rfr_bank` is 0 and `rfr_overrun` is 0.
- R2: The interval is `REFRESH_PERIOD / (BANKS_PER_RANK * RANKS_PER_MODULE * MODULES_PER_CHAN)`, which is 48 with the defaults. Counting clock edges with reset low from 1, an interval expires on every edge whose number is a multiple of the interval. The first expiry is therefore on edge 48.
- R3: Expiry number n, counting from 0 after reset, targets bank n modulo the total bank count. `rfr_bank` holds that bank index in binary from the edge of expiry onwards. After bank 31 the next target is bank 0.
- R4: Once `rfr_req` is high, it stays high until a clock edge on which `rfr_grant` is high. After that edge it reads 0, unless an interval expired on the same edge.
- R5: `rfr_grant` has no effect while `rfr_req` is low: the request, the bank and the overrun flag are unchanged.
- R6: If an interval expires while `rfr_req` is high and `rfr_grant` is low on that edge, then:
  - `rfr_overrun` becomes 1 and stays 1 until reset;
  - `rfr_req` stays high;
  - `rfr_bank` moves to the newly due bank.
- R7: If an interval expires on the same edge that grants a pending request, no overrun is flagged, and `rfr_req` stays high for the new bank.
- R8: The division truncates, and the remainder is never carried over. With a period of 100 and 3 banks in total, a request is raised every 33 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rfr_grant | input | 1 | The scheduler accepts the pending refresh |
| rfr_req | output | 1 | A refresh is pending |
| rfr_bank | output | BANK_W | Bank index of the pending refresh |
| rfr_overrun | output | 1 | Sticky: an interval expired while a request was still ungranted |

## Verification
The assertions take no assumptions about `rfr_grant`. It may be high or low on any cycle, including cycles with no pending request, and the properties must hold either way.

The bench drives the grant with a pseudo-random source whose acceptance probability changes from phase to phase. One phase grants almost every cycle, one rarely grants, and one holds the grant low for long stretches so that overruns occur. Directed sequences place a grant exactly on an expiry edge, and hold the grant high while no request is pending. A second instance with a non-dividing period checks that the remainder is truncated.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  function automatic int unsigned calc_interval(input int unsigned period,
                                                input int unsigned banks);
    int unsigned q;
    q = period / banks;
    return (q == 0) ? 1 : q;
  endfunction
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int unsigned INTERVAL = 48
) (
  input  logic clk,
  input  logic rst,
  output logic expire
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= RELOAD;
    else if (expire) cnt <= RELOAD;
    else cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/refsched_rotator.sv
module refsched_rotator #(
  parameter int unsigned TOTAL = 32,
  parameter int unsigned BW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [BW-1:0] next_bank
);
  localparam logic [BW-1:0] LAST = BW'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) next_bank <= '0;
    else if (step) next_bank <= (next_bank == LAST) ? '0 : next_bank + 1'b1;
  end
endmodule

// File: rtl/refsched_handshake.sv
module refsched_handshake #(
  parameter int unsigned BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expire,
  input  logic [BW-1:0] due_bank,
  input  logic          grant,
  output logic          req,
  output logic [BW-1:0] bank,
  output logic          overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      bank    <= '0;
      overrun <= 1'b0;
    end else if (expire) begin
      req  <= 1'b1;
      bank <= due_bank;
      if (req && !grant) overrun <= 1'b1;
    end else if (req && grant) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned REFRESH_PERIOD   = 1560,
  parameter int unsigned BANKS_PER_RANK   = 8,
  parameter int unsigned RANKS_PER_MODULE = 2,
  parameter int unsigned MODULES_PER_CHAN = 2,
  localparam int unsigned TOTAL_BANKS = BANKS_PER_RANK * RANKS_PER_MODULE * MODULES_PER_CHAN,
  localparam int unsigned BANK_W = (TOTAL_BANKS > 1) ? $clog2(TOTAL_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rfr_grant,
  output logic              rfr_req,
  output logic [BANK_W-1:0] rfr_bank,
  output logic              rfr_overrun
);
  localparam int unsigned INTERVAL =
    refsched_pkg::calc_interval(REFRESH_PERIOD, TOTAL_BANKS);

  logic              expire;
  logic [BANK_W-1:0] due_bank;

  refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .expire(expire)
  );

  refsched_rotator #(.TOTAL(TOTAL_BANKS), .BW(BANK_W)) u_rot (
    .clk(clk), .rst(rst), .step(expire), .next_bank(due_bank)
  );

  refsched_handshake #(.BW(BANK_W)) u_hs (
    .clk(clk), .rst(rst), .expire(expire), .due_bank(due_bank),
    .grant(rfr_grant), .req(rfr_req), .bank(rfr_bank), .overrun(rfr_overrun)
  );
endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int unsigned INTERVAL = 48,
  parameter int unsigned TOTAL    = 32,
  parameter int unsigned BW       = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rfr_grant,
  input logic          rfr_req,
  input logic [BW-1:0] rfr_bank,
  input logic          rfr_overrun
);
  logic [31:0] edges;
  logic        due_next;

  always_ff @(posedge clk) begin
    if (rst) edges <= '0;
    else edges <= edges + 1'b1;
  end

  assign due_next = (((edges + 32'd1) % INTERVAL) == 0);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!rfr_req && !rfr_overrun && rfr_bank == '0));

  a_r2_rise_on_interval: assert property (@(posedge clk) disable iff (rst)
    $rose(rfr_req) |-> ((edges % INTERVAL) == 0));

  a_r3_bank_in_range: assert property (@(posedge clk) disable iff (rst)
    (32'(rfr_bank) < TOTAL));

  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (rfr_req && !rfr_grant) |=> rfr_req);

  a_r5_idle_grant_ignored: assert property (@(posedge clk) disable iff (rst)
    (!rfr_req && !due_next) |=> (!rfr_req && $stable(rfr_bank) && $stable(rfr_overrun)));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    rfr_overrun |=> rfr_overrun);

  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rfr_overrun) |-> $past(rfr_req && !rfr_grant));
endmodule

bind dram_refresh_sched refsched_checker #(
  .INTERVAL(INTERVAL), .TOTAL(TOTAL_BANKS), .BW(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .rfr_grant(rfr_grant), .rfr_req(rfr_req),
  .rfr_bank(rfr_bank), .rfr_overrun(rfr_overrun)
);

// File: tb/dram_refresh_sched_tb.sv
module refsched_ref #(
  parameter int unsigned STEP  = 48,
  parameter int unsigned BANKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  output logic e_req,
  output int   e_bank,
  output logic e_ovr
);
  int edges;
  int fired;

  always @(posedge clk) begin
    if (rst) begin
      edges <= 0; fired <= 0; e_req <= 0; e_bank <= 0; e_ovr <= 0;
    end else begin
      edges <= edges + 1;
      if (((edges + 1) % STEP) == 0) begin
        e_bank <= fired % BANKS;
        fired  <= fired + 1;
        if (e_req && !grant) e_ovr <= 1;
        e_req <= 1;
      end else if (e_req && grant) begin
        e_req <= 0;
      end
    end
  end
endmodule

module dram_refresh_sched_tb;
  localparam int unsigned STEP_A  = 1560 / 32;
  localparam int unsigned STEP_B  = 100 / 3;
  localparam int unsigned BANKS_A = 32;
  localparam int unsigned BANKS_B = 3;

  logic clk = 0;
  logic rst = 1;
  logic g_a = 0, g_b = 0;
  logic req_a, ovr_a, req_b, ovr_b;
  logic [4:0] bank_a;
  logic [1:0] bank_b;
  logic e_req_a, e_ovr_a, e_req_b, e_ovr_b;
  int e_bank_a, e_bank_b;
  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_refresh_sched u_dut (
    .clk(clk), .rst(rst), .rfr_grant(g_a),
    .rfr_req(req_a), .rfr_bank(bank_a), .rfr_overrun(ovr_a)
  );

  dram_refresh_sched #(.REFRESH_PERIOD(100), .BANKS_PER_RANK(3),
                       .RANKS_PER_MODULE(1), .MODULES_PER_CHAN(1)) u_dut_small (
    .clk(clk), .rst(rst), .rfr_grant(g_b),
    .rfr_req(req_b), .rfr_bank(bank_b), .rfr_overrun(ovr_b)
  );

  refsched_ref #(.STEP(STEP_A), .BANKS(BANKS_A)) u_ref_a (
    .clk(clk), .rst(rst), .grant(g_a),
    .e_req(e_req_a), .e_bank(e_bank_a), .e_ovr(e_ovr_a)
  );

  refsched_ref #(.STEP(STEP_B), .BANKS(BANKS_B)) u_ref_b (
    .clk(clk), .rst(rst), .grant(g_b),
    .e_req(e_req_b), .e_bank(e_bank_b), .e_ovr(e_ovr_b)
  );

  function automatic int grant_roll(input int unsigned chance);
    return (($urandom % 100) < chance) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2/R4/R5 req", req_a, e_req_a);
    check("R3 bank", bank_a, e_bank_a);
    check("R6/R7 overrun", ovr_a, e_ovr_a);
    check("R8 small req", req_b, e_req_b);
    check("R8 small bank", bank_b, e_bank_b);
    check("R8 small overrun", ovr_b, e_ovr_b);
  endtask

  task automatic step(input int unsigned chance);
    @(negedge clk);
    cyc++;
    compare_all();
    g_a = grant_roll(chance);
    g_b = grant_roll(chance);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; g_a = 0; g_b = 0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset req", req_a, 0);
    check("R1 reset bank", bank_a, 0);
    check("R1 reset overrun", ovr_a, 0);
    rst = 0;
    cyc = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));

    // R1, R2, R5: grant held high from reset, first request on edge 48 and 33
    do_reset();
    g_a = 1; g_b = 1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      cyc++;
      if (i == STEP_A - 1) check("R5 idle grant no req", req_a, 0);
      if (i == STEP_A)     check("R2 first req edge 48", req_a, 1);
      if (i == STEP_B - 1) check("R8 no req before 33", req_b, 0);
      if (i == STEP_B)     check("R8 first req edge 33", req_b, 1);
      compare_all();
    end

    // R7 then R6: grant only on the second expiry edge, then never
    do_reset();
    g_a = 0; g_b = 0;
    for (int i = 1; i <= 3 * STEP_A; i++) begin
      @(negedge clk);
      cyc++;
      compare_all();
      if (i == 2 * STEP_A) begin
        check("R7 no overrun on coincident grant", ovr_a, 0);
        check("R7 req stays high", req_a, 1);
        check("R7 bank 1", bank_a, 1);
      end
      if (i == 3 * STEP_A) begin
        check("R6 overrun set", ovr_a, 1);
        check("R6 bank moves to 2", bank_a, 2);
      end
      g_a = (i == 2 * STEP_A - 1) ? 1 : 0;
    end

    // R3: full rotation with prompt grants, wraps back to bank 0
    do_reset();
    for (int i = 0; i < (BANKS_A + 2) * STEP_A; i++) step(90);
    check("R3 wrapped bank", bank_a, 1);

    // random phases with varying grant rate
    for (int i = 0; i < 3000; i++) step(40);
    for (int i = 0; i < 3000; i++) step(2);
    for (int i = 0; i < 2000; i++) step(0);
    check("R6 sticky overrun", ovr_a, 1);
    do_reset();
    for (int i = 0; i < 3000; i++) step(15);

    done = 1;
  end

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", guard, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule